// File: doc/BRIEF.md
# Hybrid Branch Predictor with Static Fallback

This block sits in an instruction front end and gives one prediction per presented fetch. For each request it takes the fetch PC, a 3-bit branch kind and the signed branch displacement. One clock later it returns a registered valid bit, a taken bit and a predicted target. Near branches draw on two structures. The first is a direct-mapped target buffer with partial tags, which holds a 2-bit saturating history counter and a target per entry. The second is a circular return stack that is pushed on calls and popped on returns. When a conditional branch misses the buffer, a fixed rule is used instead: a negative displacement means the branch is predicted taken, and any other displacement means it is predicted not taken.

Far transfers are never predicted. The buffer and its counters learn only through a separate retirement port, which reports each retired branch's PC, kind, outcome and resolved target. Looking up a prediction never alters the buffer. Fall-through addresses and the return addresses pushed on calls are the fetch PC plus a fixed instruction step of 4.

Top module: `hybrid_bpred`

## Requirements
- R1: Kind codes are 0 none, 1 conditional, 2 call, 3 return, 4 indirect, 5 far call, 6 interrupt return, 7 software interrupt. Kinds 0, 5, 6 and 7 give out_valid=0 and out_taken=0, and they leave the return stack untouched.
- R2: Outputs are registered. A request presented in one cycle is reflected on out_valid, out_taken and out_target after the next rising edge. A cycle with req_valid low gives out_valid=0.
- R3: A conditional branch that misses the buffer uses the static rule. If req_disp is negative (bit 31 set), the prediction is taken with target req_pc+req_disp. Otherwise it is not taken with target req_pc+4.
- R4: A conditional branch that hits the buffer is predicted taken when its counter is 2 or 3, and the target is then the stored target. With a counter of 0 or 1 it is predicted not taken with target req_pc+4, whatever the displacement.
- R5: A retirement update that hits moves the counter up by one if taken and down by one if not taken, saturating at 3 and 0. The stored target is replaced only on a taken outcome.
- R6: The buffer is indexed by PC bits [7:2] and tagged with PC bits [15:8]. A retirement update that misses replaces the entry at its index, storing the tag and target and setting the counter to 2 if taken or 1 if not taken.
- R7: The buffer changes only on retirement updates of kinds 1, 2 or 4. Predictions, and retirement reports of other kinds, leave it unchanged.
- R8: A call is always predicted taken. Its target is the stored target on a hit and req_pc+req_disp on a miss. Each call pushes req_pc+4 onto the return stack.
- R9: A return pops the return stack and predicts taken to the most recently pushed address that has not yet been popped (last in, first out).
- R10: A return on an empty return stack gives out_valid=0.
- R11: The return stack holds 16 entries. A push when it is full overwrites the oldest entry, so after 17 calls, 16 returns yield the 16 newest addresses and a 17th return gives no prediction.
- R12: An indirect branch that hits is predicted taken to the stored target. One that misses gives out_valid=0.
- R13: After reset, out_valid is 0, the buffer is empty and the return stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A fetch needs a prediction this cycle |
| req_pc | input | 32 | Fetch PC of the branch |
| req_kind | input | 3 | Branch kind code |
| req_disp | input | 32 | Signed branch displacement |
| out_valid | output | 1 | Registered: a prediction is given |
| out_taken | output | 1 | Registered: predicted taken |
| out_target | output | 32 | Registered: predicted next PC |
| upd_valid | input | 1 | A branch retires this cycle |
| upd_pc | input | 32 | PC of the retired branch |
| upd_kind | input | 3 | Kind code of the retired branch |
| upd_taken | input | 1 | Actual outcome of the retired branch |
| upd_target | input | 32 | Resolved target of the retired branch |

## Verification
A corrupted counter or tag shows up on the very next prediction for that PC. It flips out_taken or replaces the stored target with the static fallback, so each counter step is probed one cycle after its retirement update. Where possible the probe uses a displacement whose sign disagrees with the expected dynamic outcome, so the two cases cannot be confused.

Return stack faults behave differently. A wrong pointer or count stays hidden until a return is predicted. The bench therefore drains the stack right after nesting, after far transfers, and after an overflow, and it checks the final empty pop.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

  typedef enum logic [2:0] {
    BK_NONE    = 3'd0,
    BK_COND    = 3'd1,
    BK_CALL    = 3'd2,
    BK_RET     = 3'd3,
    BK_IND     = 3'd4,
    BK_FARCALL = 3'd5,
    BK_IRET    = 3'd6,
    BK_SWINT   = 3'd7
  } br_kind_e;

  // Kinds whose retirement trains the target buffer
  function automatic logic trains_buffer(input br_kind_e k);
    return (k == BK_COND) || (k == BK_CALL) || (k == BK_IND);
  endfunction

endpackage

// File: rtl/hbp_btb.sv
module hbp_btb #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6,
  parameter int TAG_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [PC_W-1:0]       lk_pc,
  output logic                  lk_hit,
  output logic [1:0]            lk_ctr,
  output logic [PC_W-1:0]       lk_tgt,
  input  logic                  wr_en,
  input  logic [PC_W-1:0]       wr_pc,
  input  logic                  wr_taken,
  input  logic [PC_W-1:0]       wr_tgt,
  output logic [(1<<IDX_W)-1:0] vld_vec
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int IDX_LO  = 2;
  localparam int TAG_LO  = IDX_LO + IDX_W;
  localparam int TAG_HI  = TAG_LO + TAG_W;

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_mem [ENTRIES];
  logic [1:0]         ctr_mem [ENTRIES];
  logic [PC_W-1:0]    tgt_mem [ENTRIES];

  logic [IDX_W-1:0] lk_idx, wr_idx;
  logic [TAG_W-1:0] lk_tag, wr_tag;
  logic             wr_hit;
  logic [1:0]       wr_ctr_old, wr_ctr_new;
  logic             unused_pc_bits;

  assign lk_idx = lk_pc[TAG_LO-1:IDX_LO];
  assign lk_tag = lk_pc[TAG_HI-1:TAG_LO];
  assign wr_idx = wr_pc[TAG_LO-1:IDX_LO];
  assign wr_tag = wr_pc[TAG_HI-1:TAG_LO];
  assign unused_pc_bits = ^{lk_pc[IDX_LO-1:0], lk_pc[PC_W-1:TAG_HI],
                            wr_pc[IDX_LO-1:0], wr_pc[PC_W-1:TAG_HI]};

  // Lookup port: read-only
  assign lk_hit = vld_q[lk_idx] && (tag_mem[lk_idx] == lk_tag);
  assign lk_ctr = ctr_mem[lk_idx];
  assign lk_tgt = tgt_mem[lk_idx];

  // Retirement port: read-modify-write of the counter
  assign wr_hit     = vld_q[wr_idx] && (tag_mem[wr_idx] == wr_tag);
  assign wr_ctr_old = ctr_mem[wr_idx];

  always_comb begin
    if (!wr_hit)
      wr_ctr_new = wr_taken ? 2'd2 : 2'd1;
    else if (wr_taken)
      wr_ctr_new = (wr_ctr_old == 2'd3) ? 2'd3 : wr_ctr_old + 2'd1;
    else
      wr_ctr_new = (wr_ctr_old == 2'd0) ? 2'd0 : wr_ctr_old - 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst)
      vld_q <= '0;
    else if (wr_en)
      vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx] <= wr_tag;
      ctr_mem[wr_idx] <= wr_ctr_new;
      if (!wr_hit || wr_taken)
        tgt_mem[wr_idx] <= wr_tgt;
    end
  end

  assign vld_vec = vld_q;

endmodule

// File: rtl/hbp_ras.sv
module hbp_ras #(
  parameter int PC_W  = 32,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [PC_W-1:0]            push_addr,
  input  logic                       pop,
  output logic                       top_valid,
  output logic [PC_W-1:0]            top_addr,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [PC_W-1:0] stk_mem [DEPTH];
  logic [PW-1:0]   wp_q;
  logic [CW-1:0]   cnt_q;
  logic [PW-1:0]   top_ptr;

  assign top_ptr   = wp_q - 1'b1;
  assign top_valid = (cnt_q != '0);
  assign top_addr  = stk_mem[top_ptr];
  assign count     = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      cnt_q <= '0;
    end else if (push) begin
      wp_q <= wp_q + 1'b1;
      if (cnt_q != FULL)
        cnt_q <= cnt_q + 1'b1;
    end else if (pop && top_valid) begin
      wp_q  <= top_ptr;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push)
      stk_mem[wp_q] <= push_addr;
  end

endmodule

// File: rtl/hbp_select.sv
module hbp_select
  import hbp_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int LINK_OFS = 4
) (
  input  logic [2:0]      kind,
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] disp,
  input  logic            btb_hit,
  input  logic [1:0]      btb_ctr,
  input  logic [PC_W-1:0] btb_tgt,
  input  logic            ras_valid,
  input  logic [PC_W-1:0] ras_top,
  output logic            sel_valid,
  output logic            sel_taken,
  output logic [PC_W-1:0] sel_target,
  output logic            do_push,
  output logic            do_pop
);
  logic [PC_W-1:0] fall_pc, rel_pc;

  assign fall_pc = pc + PC_W'(LINK_OFS);
  assign rel_pc  = pc + disp;

  always_comb begin
    sel_valid  = 1'b0;
    sel_taken  = 1'b0;
    sel_target = '0;
    do_push    = 1'b0;
    do_pop     = 1'b0;
    unique case (br_kind_e'(kind))
      BK_COND: begin
        sel_valid  = 1'b1;
        sel_taken  = btb_hit ? btb_ctr[1] : disp[PC_W-1];
        sel_target = !sel_taken ? fall_pc : (btb_hit ? btb_tgt : rel_pc);
      end
      BK_CALL: begin
        sel_valid  = 1'b1;
        sel_taken  = 1'b1;
        sel_target = btb_hit ? btb_tgt : rel_pc;
        do_push    = 1'b1;
      end
      BK_RET: begin
        do_pop     = 1'b1;
        sel_valid  = ras_valid;
        sel_taken  = ras_valid;
        sel_target = ras_valid ? ras_top : '0;
      end
      BK_IND: begin
        sel_valid  = btb_hit;
        sel_taken  = btb_hit;
        sel_target = btb_hit ? btb_tgt : '0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/hybrid_bpred.sv
module hybrid_bpred
  import hbp_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int IDX_W     = 6,
  parameter int TAG_W     = 8,
  parameter int RAS_DEPTH = 16,
  parameter int LINK_OFS  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [PC_W-1:0] req_pc,
  input  logic [2:0]      req_kind,
  input  logic [PC_W-1:0] req_disp,
  output logic            out_valid,
  output logic            out_taken,
  output logic [PC_W-1:0] out_target,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic [2:0]      upd_kind,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int CW      = $clog2(RAS_DEPTH+1);

  logic               btb_hit;
  logic [1:0]         btb_ctr;
  logic [PC_W-1:0]    btb_tgt;
  logic [ENTRIES-1:0] btb_vld;
  logic               btb_wr;
  logic               ras_valid;
  logic [PC_W-1:0]    ras_top;
  logic [CW-1:0]      ras_cnt;
  logic               sel_valid, sel_taken, sel_push, sel_pop;
  logic [PC_W-1:0]    sel_target;

  assign btb_wr = upd_valid && trains_buffer(br_kind_e'(upd_kind));

  hbp_btb #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_btb (
    .clk      (clk),
    .rst      (rst),
    .lk_pc    (req_pc),
    .lk_hit   (btb_hit),
    .lk_ctr   (btb_ctr),
    .lk_tgt   (btb_tgt),
    .wr_en    (btb_wr),
    .wr_pc    (upd_pc),
    .wr_taken (upd_taken),
    .wr_tgt   (upd_target),
    .vld_vec  (btb_vld)
  );

  hbp_ras #(.PC_W(PC_W), .DEPTH(RAS_DEPTH)) u_ras (
    .clk       (clk),
    .rst       (rst),
    .push      (req_valid && sel_push),
    .push_addr (req_pc + PC_W'(LINK_OFS)),
    .pop       (req_valid && sel_pop),
    .top_valid (ras_valid),
    .top_addr  (ras_top),
    .count     (ras_cnt)
  );

  hbp_select #(.PC_W(PC_W), .LINK_OFS(LINK_OFS)) u_sel (
    .kind       (req_kind),
    .pc         (req_pc),
    .disp       (req_disp),
    .btb_hit    (btb_hit),
    .btb_ctr    (btb_ctr),
    .btb_tgt    (btb_tgt),
    .ras_valid  (ras_valid),
    .ras_top    (ras_top),
    .sel_valid  (sel_valid),
    .sel_taken  (sel_taken),
    .sel_target (sel_target),
    .do_push    (sel_push),
    .do_pop     (sel_pop)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_taken  <= 1'b0;
      out_target <= '0;
    end else begin
      out_valid  <= req_valid && sel_valid;
      out_taken  <= req_valid && sel_taken;
      out_target <= sel_target;
    end
  end

endmodule

// File: rtl/hbp_checker.sv
module hbp_checker #(
  parameter int PC_W      = 32,
  parameter int IDX_W     = 6,
  parameter int RAS_DEPTH = 16
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         req_valid,
  input logic [2:0]                   req_kind,
  input logic                         upd_valid,
  input logic                         out_valid,
  input logic                         out_taken,
  input logic [$clog2(RAS_DEPTH+1)-1:0] ras_cnt,
  input logic [(1<<IDX_W)-1:0]        btb_vld
);
  localparam int CW = $clog2(RAS_DEPTH+1);
  localparam logic [CW-1:0] FULL = CW'(RAS_DEPTH);

  // R2: an idle request slot yields no prediction
  a_r2_idle_no_pred: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);

  // R2: taken is only reported alongside a valid prediction
  a_r2_taken_has_valid: assert property (@(posedge clk) disable iff (rst)
    out_taken |-> out_valid);

  // R1: far transfers are never predicted
  a_r1_far_no_pred: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind >= 3'd5) |=> !out_valid);

  // R1: far transfers and none leave the return stack depth alone
  a_r1_far_keeps_stack: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_kind >= 3'd5 || req_kind == 3'd0)) |=> $stable(ras_cnt));

  // R8: calls are always predicted taken
  a_r8_call_taken: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 3'd2) |=> (out_valid && out_taken));

  // R9: a return with entries present removes exactly one
  a_r9_pop_one: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 3'd3 && ras_cnt != '0) |=>
      (ras_cnt == CW'($past(ras_cnt) - 1'b1)));

  // R10: a return on an empty stack gives no prediction
  a_r10_empty_pop: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 3'd3 && ras_cnt == '0) |=> !out_valid);

  // R11: pushing into a full stack keeps it full
  a_r11_full_stays: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 3'd2 && ras_cnt == FULL) |=> (ras_cnt == FULL));

  // R7: without a retirement update the buffer occupancy does not move
  a_r7_btb_quiet: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> $stable(btb_vld));

endmodule

bind hybrid_bpred hbp_checker #(
  .PC_W(PC_W), .IDX_W(IDX_W), .RAS_DEPTH(RAS_DEPTH)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_kind  (req_kind),
  .upd_valid (upd_valid),
  .out_valid (out_valid),
  .out_taken (out_taken),
  .ras_cnt   (ras_cnt),
  .btb_vld   (btb_vld)
);

// File: tb/hybrid_bpred_bench.sv
`timescale 1ns/1ps
module hybrid_bpred_bench;

  localparam logic [2:0] K_NONE = 3'd0, K_COND = 3'd1, K_CALL = 3'd2, K_RET = 3'd3,
                         K_IND = 3'd4, K_FAR = 3'd5, K_IRET = 3'd6, K_SWI = 3'd7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_pc = '0;
  logic [2:0]  req_kind = '0;
  logic [31:0] req_disp = '0;
  logic        out_valid, out_taken;
  logic [31:0] out_target;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic [2:0]  upd_kind = '0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int          due;
    bit          valid;
    bit          taken;
    logic [31:0] target;
    string       rq;
  } exp_t;

  exp_t sb[$];

  always #2.5 clk = ~clk;

  hybrid_bpred u_hybrid_bpred (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_pc(req_pc), .req_kind(req_kind), .req_disp(req_disp),
    .out_valid(out_valid), .out_taken(out_taken), .out_target(out_target),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_kind(upd_kind),
    .upd_taken(upd_taken), .upd_target(upd_target)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Driver: present one prediction request and queue its expected result
  task automatic predict(input logic [31:0] pc, input logic [2:0] k, input logic [31:0] d,
                         input bit ev, input bit et, input logic [31:0] etgt, input string rq);
    @(posedge clk); #1;
    req_valid = 1'b1; req_pc = pc; req_kind = k; req_disp = d;
    upd_valid = 1'b0;
    sb.push_back('{cyc + 1, ev, et, etgt, rq});
  endtask

  // Driver: one retirement report; the idle request slot must give no prediction
  task automatic retire(input logic [31:0] pc, input logic [2:0] k, input bit t,
                        input logic [31:0] tgt);
    @(posedge clk); #1;
    req_valid = 1'b0;
    upd_valid = 1'b1; upd_pc = pc; upd_kind = k; upd_taken = t; upd_target = tgt;
    sb.push_back('{cyc + 1, 1'b0, 1'b0, 32'h0, "R2"});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      req_valid = 1'b0; upd_valid = 1'b0;
    end
  endtask

  // Monitor: compare results as they appear, sampled at the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (out_valid !== e.valid ||
          (e.valid && (out_taken !== e.taken || out_target !== e.target))) begin
        errors++;
        $display("FAIL %s: got valid=%0b taken=%0b target=%h, expected valid=%0b taken=%0b target=%h",
                 e.rq, out_valid, out_taken, out_target, e.valid, e.taken, e.target);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got hung run, expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R13: got out_valid=%0b, expected 0", out_valid);
    end

    // R13/R10: empty stack after reset
    predict(32'h0000_0040, K_RET, 32'h0, 0, 0, 32'h0, "R13");
    // R1: unpredicted kinds
    predict(32'h0000_0800, K_FAR,  32'h10, 0, 0, 32'h0, "R1");
    predict(32'h0000_0804, K_IRET, 32'h10, 0, 0, 32'h0, "R1");
    predict(32'h0000_0808, K_SWI,  32'h10, 0, 0, 32'h0, "R1");
    predict(32'h0000_080C, K_NONE, 32'h10, 0, 0, 32'h0, "R1");
    // R2: idle slot
    idle(1);
    sb.push_back('{cyc + 1, 1'b0, 1'b0, 32'h0, "R2"});
    idle(1);
    // R3: static fallback on miss
    predict(32'h0000_0100, K_COND, 32'hFFFF_FFF0, 1, 1, 32'h0000_00F0, "R3");
    predict(32'h0000_0100, K_COND, 32'h0000_0020, 1, 0, 32'h0000_0104, "R3");
    // R6: allocate taken -> counter 2
    retire(32'h0000_0100, K_COND, 1, 32'h0000_0080);
    predict(32'h0000_0100, K_COND, 32'h0000_0008, 1, 1, 32'h0000_0080, "R6");
    // R7: repeated predictions do not train
    predict(32'h0000_0100, K_COND, 32'h0000_0008, 1, 1, 32'h0000_0080, "R7");
    predict(32'h0000_0100, K_COND, 32'h0000_0008, 1, 1, 32'h0000_0080, "R7");
    // R5/R4: counter walk 2->1->0->0->1->2->3->3->2
    retire(32'h0000_0100, K_COND, 0, 32'h0000_0999);
    predict(32'h0000_0100, K_COND, 32'hFFFF_FFF0, 1, 0, 32'h0000_0104, "R5");
    retire(32'h0000_0100, K_COND, 0, 32'h0000_0999);
    predict(32'h0000_0100, K_COND, 32'hFFFF_FFF0, 1, 0, 32'h0000_0104, "R5");
    retire(32'h0000_0100, K_COND, 0, 32'h0000_0999);
    predict(32'h0000_0100, K_COND, 32'hFFFF_FFF0, 1, 0, 32'h0000_0104, "R5");
    retire(32'h0000_0100, K_COND, 1, 32'h0000_0080);
    predict(32'h0000_0100, K_COND, 32'hFFFF_FFF0, 1, 0, 32'h0000_0104, "R4");
    retire(32'h0000_0100, K_COND, 1, 32'h0000_0080);
    predict(32'h0000_0100, K_COND, 32'h0000_0008, 1, 1, 32'h0000_0080, "R4");
    retire(32'h0000_0100, K_COND, 1, 32'h0000_0080);
    retire(32'h0000_0100, K_COND, 1, 32'h0000_0080);
    predict(32'h0000_0100, K_COND, 32'h0000_0008, 1, 1, 32'h0000_0080, "R5");
    retire(32'h0000_0100, K_COND, 0, 32'h0000_0999);
    predict(32'h0000_0100, K_COND, 32'h0000_0008, 1, 1, 32'h0000_0080, "R5");
    // R6: aliasing PC 0x200 (same index, tag 2) replaces the entry, not taken -> 1
    retire(32'h0000_0200, K_COND, 0, 32'h0000_0300);
    predict(32'h0000_0100, K_COND, 32'hFFFF_FFF0, 1, 1, 32'h0000_00F0, "R6");
    predict(32'h0000_0200, K_COND, 32'hFFFF_FFF8, 1, 0, 32'h0000_0204, "R6");
    retire(32'h0000_0200, K_COND, 1, 32'h0000_0300);
    predict(32'h0000_0200, K_COND, 32'h0000_0008, 1, 1, 32'h0000_0300, "R6");
    // R7: retirement of return / far kinds does not train
    retire(32'h0000_0400, K_RET, 1, 32'h0000_5550);
    retire(32'h0000_0400, K_FAR, 1, 32'h0000_5550);
    predict(32'h0000_0400, K_COND, 32'h0000_0008, 1, 0, 32'h0000_0404, "R7");
    // R12: indirect
    predict(32'h0000_0500, K_IND, 32'h0, 0, 0, 32'h0, "R12");
    retire(32'h0000_0500, K_IND, 1, 32'h0000_9000);
    predict(32'h0000_0500, K_IND, 32'h0, 1, 1, 32'h0000_9000, "R12");
    // R8/R9/R10: call then return
    predict(32'h0000_0600, K_CALL, 32'h0000_0100, 1, 1, 32'h0000_0700, "R8");
    predict(32'h0000_0650, K_RET,  32'h0, 1, 1, 32'h0000_0604, "R9");
    predict(32'h0000_0654, K_RET,  32'h0, 0, 0, 32'h0, "R10");
    // R9: nesting
    predict(32'h0000_1000, K_CALL, 32'h40, 1, 1, 32'h0000_1040, "R8");
    predict(32'h0000_2000, K_CALL, 32'h40, 1, 1, 32'h0000_2040, "R8");
    predict(32'h0000_2050, K_RET,  32'h0,  1, 1, 32'h0000_2004, "R9");
    predict(32'h0000_1050, K_RET,  32'h0,  1, 1, 32'h0000_1004, "R9");
    // R1: far transfers leave the stack alone
    predict(32'h0000_3000, K_CALL, 32'h40, 1, 1, 32'h0000_3040, "R8");
    predict(32'h0000_3100, K_FAR,  32'h40, 0, 0, 32'h0, "R1");
    predict(32'h0000_3104, K_IRET, 32'h0,  0, 0, 32'h0, "R1");
    predict(32'h0000_3108, K_NONE, 32'h0,  0, 0, 32'h0, "R1");
    predict(32'h0000_3050, K_RET,  32'h0,  1, 1, 32'h0000_3004, "R1");
    predict(32'h0000_3054, K_RET,  32'h0,  0, 0, 32'h0, "R10");
    // R8: call hitting the buffer uses the stored target
    retire(32'h0000_0700, K_CALL, 1, 32'h0000_8888);
    predict(32'h0000_0700, K_CALL, 32'h10, 1, 1, 32'h0000_8888, "R8");
    predict(32'h0000_0790, K_RET,  32'h0,  1, 1, 32'h0000_0704, "R9");
    // R11: overflow by one
    for (int i = 0; i < 17; i++)
      predict(32'h0000_4000 + 32'(i) * 32'h10, K_CALL, 32'h40, 1, 1,
              32'h0000_4040 + 32'(i) * 32'h10, "R11");
    for (int i = 16; i >= 1; i--)
      predict(32'h0000_6000, K_RET, 32'h0, 1, 1, 32'h0000_4004 + 32'(i) * 32'h10, "R11");
    predict(32'h0000_6000, K_RET, 32'h0, 0, 0, 32'h0, "R11");

    idle(3);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R2: got %0d pending results, expected 0", sb.size());
    end
    finish_run();
  end

endmodule